// File: doc/BRIEF.md
# Stalling I2C Target Byte Engine

This block is the target side of an I2C port. It answers one programmable 7-bit address. It hands every address phase and every data byte to host software as an event, and it can hold SCL low until software has dealt with that event. Software writes one command word to clear the pending event. The same word decides whether the next byte received from the bus master is ACKed and whether clock stretching is used. When the master is reading, the upper half of the word carries the byte to send.

The bus pins are open-drain. The block samples SCL and SDA through a synchroniser and pulls a line low by raising the matching `*_drive_low` output. A START followed by a matching address raises the command event. So does a STOP seen while the block is addressed. Each completed data byte raises the data event, with its acknowledge recorded in the status flags. The host interface uses plain strobes with no back-pressure: a write takes effect on the clock edge where its strobe is high, and status reads are plain level outputs.

Top module: `i2c_stall_target`

## Requirements
- R1: After reset, both event flags are 0, `irq` is 0 and neither bus line is driven low.
- R2: After a START, an address byte whose upper 7 bits equal bits [7:1] of the own-address value is ACKed in the ninth clock. This raises event bit 0 (command event). Status bit 2 then holds the R/W bit of the address byte (1 = master reads) and status bit 5 is 0.
- R3: An address byte that does not match, or any address while the own-address value is 0, gets no ACK and raises no event. The engine then stays idle, and a later STOP raises no event.
- R4: When command bit 0 (stall enable) is set, SCL is held low from the falling edge that ends the ACK slot of each matched byte until a command write with bit 6 clears the event. When bit 0 is clear, SCL is never held.
- R5: A byte written by the master raises event bit 1 (data event) and appears on `rx_byte`, with status bit 2 equal to 0.
- R6: A received data byte is ACKed if command bit 3 was set in the most recent command write before that byte, and NACKed otherwise.
- R7: During a master read, the byte in bits [15:8] of a command write made with `cmd_hi` high is sent MSB first once the stall is released.
- R8: After each transmitted byte, event bit 1 is raised and status bit 3 gives the master's acknowledge (1 = ACK). After a NACK, the engine drives SDA no more until the next START or STOP.
- R9: A STOP seen while addressed raises event bit 0 with status bit 5 = 1, returns the engine to idle and releases both lines.
- R10: `irq` is high while an event is pending and command bit 4 (event mask) is 0. It is low when the mask is set, and it rises when an unmask write finds an event pending.
- R11: A command write with bit 6 set clears both event bits. A command write without bit 6 leaves them as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level on the bus |
| sda_i | input | 1 | SDA level on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low (stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| adr_wr | input | 1 | Own-address write strobe |
| adr_wdata | input | 8 | Own address in bits [7:1]; 0 disables the target |
| cmd_wr | input | 1 | Command write strobe |
| cmd_hi | input | 1 | Upper command byte valid (transmit byte) |
| cmd_wdata | input | 16 | Command word: [15:8] transmit byte, 6 clear event, 4 mask, 3 ACK next, 0 stall |
| evt_flags | output | 2 | Bit 0 command event, bit 1 data event |
| stat_flags | output | 8 | Bit 5 STOP seen, bit 3 acknowledge, bit 2 direction |
| rx_byte | output | 8 | Last byte received from the master |
| irq | output | 1 | Pending unmasked event |

## Verification
The assertions assume that the bus master obeys clock stretching and changes SDA only while SCL is low, except for START and STOP. They also assume that each SCL phase lasts longer than the synchroniser and edge-detect delay of about three clocks. The bench models an open-drain bus and holds every SCL and SDA phase for at least eight clocks. Before driving a new bit it waits until the SCL line is seen high. The host model clears events only while the engine is stalled or after the event has been observed.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RX, ST_TX, ST_ACK, ST_STALL, ST_HOLD
  } tgt_state_e;

  localparam int CMD_STALL_EN = 0;
  localparam int CMD_ACK_EN   = 3;
  localparam int CMD_MASK_EVT = 4;
  localparam int CMD_CLR_EVT  = 6;

  localparam int STAT_RW_BIT   = 2;
  localparam int STAT_ACK_BIT  = 3;
  localparam int STAT_STOP_BIT = 5;

  localparam int EV_CMD_BIT = 0;
  localparam int EV_DAT_BIT = 1;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '1;
      else        sr <= {sr[STAGES-2:0], d[g]};
    end
    assign q[g] = sr[STAGES-1];
  end
endmodule

// File: rtl/i2c_tgt_host.sv
module i2c_tgt_host import i2c_tgt_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adr_wr,
  input  logic [BYTE_W-1:0] adr_wdata,
  input  logic              cmd_wr,
  input  logic              cmd_hi,
  input  logic [2*BYTE_W-1:0] cmd_wdata,
  input  logic              set_cmd,
  input  logic              set_dat,
  input  logic              set_stop,
  input  logic              rw_in,
  input  logic              ack_in,
  input  logic [BYTE_W-1:0] rx_in,
  output logic [BYTE_W-2:0] own_addr,
  output logic              ack_en,
  output logic              stall_en,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              ev_pend,
  output logic [1:0]        evt_flags,
  output logic [7:0]        stat_flags,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              irq
);
  logic ev_cmd, ev_dat, mask_q, st_stop, st_rw, st_ack, clr;
  logic unused_bits;

  assign clr = cmd_wr & cmd_wdata[CMD_CLR_EVT];
  assign unused_bits = ^{adr_wdata[0], cmd_wdata[7], cmd_wdata[5], cmd_wdata[2:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr <= '0;
      ack_en   <= 1'b0;
      stall_en <= 1'b0;
      mask_q   <= 1'b1;
      tx_byte  <= '1;
    end else begin
      if (adr_wr) own_addr <= adr_wdata[BYTE_W-1:1];
      if (cmd_wr) begin
        ack_en   <= cmd_wdata[CMD_ACK_EN];
        stall_en <= cmd_wdata[CMD_STALL_EN];
        mask_q   <= cmd_wdata[CMD_MASK_EVT];
        if (cmd_hi) tx_byte <= cmd_wdata[2*BYTE_W-1:BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_cmd  <= 1'b0;
      ev_dat  <= 1'b0;
      st_stop <= 1'b0;
      st_rw   <= 1'b0;
      st_ack  <= 1'b0;
      rx_byte <= '0;
    end else begin
      ev_cmd <= set_cmd | (ev_cmd & ~clr);
      ev_dat <= set_dat | (ev_dat & ~clr);
      if (set_cmd | set_dat) begin
        st_stop <= set_stop;
        if (!set_stop) begin
          st_rw  <= rw_in;
          st_ack <= ack_in;
        end
      end
      if (set_dat && !rw_in) rx_byte <= rx_in;
    end
  end

  assign ev_pend   = ev_cmd | ev_dat;
  assign evt_flags = {ev_dat, ev_cmd};
  assign irq       = ev_pend & ~mask_q;

  always_comb begin
    stat_flags = '0;
    stat_flags[STAT_STOP_BIT] = st_stop;
    stat_flags[STAT_ACK_BIT]  = st_ack;
    stat_flags[STAT_RW_BIT]   = st_rw;
  end

  // R11
  evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_cmd && !set_dat) |=> (evt_flags == 2'b00));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_cmd || set_dat || cmd_wr));
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm import i2c_tgt_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic              ack_en,
  input  logic              stall_en,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              ev_pend,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              set_cmd,
  output logic              set_dat,
  output logic              set_stop,
  output logic              rw_out,
  output logic              ack_out,
  output logic [BYTE_W-1:0] rx_out
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  tgt_state_e state;
  logic scl_p, sda_p;
  logic rise, fall, start_c, stop_c, hit_stop, ack_end, adr_hit;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic addr_ph, rw_q, ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign rise     = scl_s & ~scl_p;
  assign fall     = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign hit_stop = stop_c && (state != ST_IDLE);
  assign ack_end  = (state == ST_ACK) && fall;
  assign adr_hit  = (own_addr != '0) && (sh[BYTE_W-1:1] == own_addr);

  assign set_cmd  = hit_stop | (ack_end & addr_ph);
  assign set_dat  = ack_end & ~addr_ph;
  assign set_stop = hit_stop;
  assign rw_out   = rw_q;
  assign ack_out  = ack_q;
  assign rx_out   = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sh      <= '0;
      cnt     <= '0;
      addr_ph <= 1'b0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
      sda_oe  <= 1'b0;
      scl_oe  <= 1'b0;
    end else if (hit_stop) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else if (start_c) begin
      state   <= ST_ADDR;
      cnt     <= '0;
      addr_ph <= 1'b1;
      sda_oe  <= 1'b0;
      scl_oe  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (fall && cnt == CNT_FULL) begin
            if (state == ST_RX) begin
              sda_oe <= ack_en;
              state  <= ST_ACK;
            end else if (adr_hit) begin
              sda_oe <= 1'b1;
              rw_q   <= sh[0];
              state  <= ST_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_TX: begin
          if (fall) begin
            if (cnt == CNT_FULL) begin
              sda_oe <= 1'b0;
              state  <= ST_ACK;
            end else begin
              sda_oe <= ~sh[BYTE_W-2];
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (rise) begin
            ack_q <= ~sda_s;
          end else if (fall) begin
            sda_oe <= 1'b0;
            scl_oe <= stall_en;
            state  <= ST_STALL;
          end
        end
        ST_STALL: begin
          if (!ev_pend || !stall_en) begin
            scl_oe  <= 1'b0;
            addr_ph <= 1'b0;
            cnt     <= '0;
            if (rw_q && (addr_ph || ack_q)) begin
              state  <= ST_TX;
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[BYTE_W-1];
              cnt    <= CNT_W'(1);
            end else if (rw_q) begin
              state <= ST_HOLD;
            end else begin
              state <= ST_RX;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_cmd && !set_stop) |-> (own_addr != '0));

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!sda_oe && !scl_oe));

  // R4
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !ev_pend) |=> !scl_oe);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && ev_pend && stall_en && !scl_s) |=> scl_oe);
endmodule

// File: rtl/i2c_stall_target.sv
module i2c_stall_target #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              adr_wr,
  input  logic [BYTE_W-1:0] adr_wdata,
  input  logic              cmd_wr,
  input  logic              cmd_hi,
  input  logic [2*BYTE_W-1:0] cmd_wdata,
  output logic [1:0]        evt_flags,
  output logic [7:0]        stat_flags,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              irq
);
  logic scl_s, sda_s;
  logic [BYTE_W-2:0] own_addr;
  logic [BYTE_W-1:0] tx_byte, rx_raw;
  logic ack_en, stall_en, ev_pend;
  logic set_cmd, set_dat, set_stop, rw_w, ack_w;

  i2c_tgt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_i, scl_i}), .q({sda_s, scl_s})
  );

  i2c_tgt_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .own_addr(own_addr), .ack_en(ack_en), .stall_en(stall_en),
    .tx_byte(tx_byte), .ev_pend(ev_pend),
    .scl_oe(scl_drive_low), .sda_oe(sda_drive_low),
    .set_cmd(set_cmd), .set_dat(set_dat), .set_stop(set_stop),
    .rw_out(rw_w), .ack_out(ack_w), .rx_out(rx_raw)
  );

  i2c_tgt_host #(.BYTE_W(BYTE_W)) u_host (
    .clk(clk), .rst_n(rst_n), .adr_wr(adr_wr), .adr_wdata(adr_wdata),
    .cmd_wr(cmd_wr), .cmd_hi(cmd_hi), .cmd_wdata(cmd_wdata),
    .set_cmd(set_cmd), .set_dat(set_dat), .set_stop(set_stop),
    .rw_in(rw_w), .ack_in(ack_w), .rx_in(rx_raw),
    .own_addr(own_addr), .ack_en(ack_en), .stall_en(stall_en),
    .tx_byte(tx_byte), .ev_pend(ev_pend), .evt_flags(evt_flags),
    .stat_flags(stat_flags), .rx_byte(rx_byte), .irq(irq)
  );
endmodule

// File: tb/sim_i2c_stall_target.sv
`timescale 1ns/1ps
module sim_i2c_stall_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic adr_wr = 1'b0, cmd_wr = 1'b0, cmd_hi = 1'b0;
  logic [7:0]  adr_wdata = '0;
  logic [15:0] cmd_wdata = '0;
  logic scl_drive_low, sda_drive_low, irq;
  logic [1:0] evt_flags;
  logic [7:0] stat_flags, rx_byte;
  logic scl, sda;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign scl = m_scl & ~scl_drive_low;
  assign sda = m_sda & ~sda_drive_low;

  i2c_stall_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .adr_wr(adr_wr), .adr_wdata(adr_wdata), .cmd_wr(cmd_wr), .cmd_hi(cmd_hi),
    .cmd_wdata(cmd_wdata), .evt_flags(evt_flags), .stat_flags(stat_flags),
    .rx_byte(rx_byte), .irq(irq)
  );

  // fields: own[26:19] addr7[18:12] rw[11] data[10:3] ack_en[2] master_ack[1] match[0]
  localparam logic [26:0] VEC [6] = '{
    {8'h84, 7'h42, 1'b0, 8'hA5, 1'b1, 1'b0, 1'b1},
    {8'h84, 7'h42, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b1},
    {8'h84, 7'h42, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b1},
    {8'h84, 7'h42, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b1},
    {8'h84, 7'h43, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'h00, 7'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    int n = 0;
    while (scl !== 1'b1 && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) chk("R4 stall never released", 32'(scl), 32'd1);
  endtask

  task automatic pulse(output logic b);
    m_scl = 1'b1;
    wait_scl_high();
    cyc(4); b = sda; cyc(4);
    m_scl = 1'b0;
    cyc(8);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; cyc(4);
    m_scl = 1'b1; wait_scl_high(); cyc(8);
    m_sda = 1'b0; cyc(8);
    m_scl = 1'b0; cyc(8);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; cyc(4);
    m_scl = 1'b1; wait_scl_high(); cyc(8);
    m_sda = 1'b1; cyc(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) begin m_sda = b[i]; cyc(2); pulse(s); end
    m_sda = 1'b1; cyc(2);
    pulse(s);
    acked = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    logic s;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin pulse(s); b[i] = s; end
    m_sda = ~mack; cyc(2);
    pulse(s);
    m_sda = 1'b1; cyc(2);
  endtask

  task automatic host_cmd(input logic hi, input logic [15:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_hi = hi; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0; cmd_hi = 1'b0;
    cyc(6);
  endtask

  task automatic host_adr(input logic [7:0] a);
    @(negedge clk); adr_wr = 1'b1; adr_wdata = a;
    @(negedge clk); adr_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic ack, s;
    logic [7:0] rb;
    cyc(5); rst_n = 1'b1; cyc(4);
    // R1 reset state
    chk("R1 evt_flags", 32'(evt_flags), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 scl drive", 32'(scl_drive_low), 0);
    chk("R1 sda drive", 32'(sda_drive_low), 0);

    host_cmd(1'b0, 16'h0049);
    for (int i = 0; i < 6; i++) begin
      logic [26:0] v = VEC[i];
      host_adr(v[26:19]);
      bus_start();
      send_byte({v[18:12], v[11]}, ack);
      if (!v[0]) begin
        chk("R3 no address ack", 32'(ack), 0);
        chk("R3 no event", 32'(evt_flags), 0);
        bus_stop();
        chk("R3 stop while idle", 32'(evt_flags), 0);
        continue;
      end
      chk("R2 address ack", 32'(ack), 1);
      chk("R2 command event", 32'(evt_flags), 1);
      chk("R2 direction", 32'(stat_flags[2]), 32'(v[11]));
      chk("R2 stop flag low", 32'(stat_flags[5]), 0);
      chk("R4 stalled after address", 32'(scl_drive_low), 1);
      chk("R10 irq pending", 32'(irq), 1);
      if (!v[11]) begin
        host_cmd(1'b0, 16'h0041 | (16'(v[2]) << 3));
        chk("R4 released", 32'(scl_drive_low), 0);
        send_byte(v[10:3], ack);
        chk("R6 data ack", 32'(ack), 32'(v[2]));
        chk("R5 data event", 32'(evt_flags), 2);
        chk("R5 rx byte", 32'(rx_byte), 32'(v[10:3]));
        chk("R5 direction", 32'(stat_flags[2]), 0);
        host_cmd(1'b0, 16'h0049);
        chk("R11 cleared", 32'(evt_flags), 0);
      end else begin
        host_cmd(1'b1, {v[10:3], 8'h41});
        read_byte(v[1], rb);
        chk("R7 tx byte", 32'(rb), 32'(v[10:3]));
        chk("R8 data event", 32'(evt_flags), 2);
        chk("R8 master ack", 32'(stat_flags[3]), 32'(v[1]));
        host_cmd(1'b1, 16'hFF41);
        chk("R11 cleared", 32'(evt_flags), 0);
        if (!v[1]) begin
          m_sda = 1'b1; cyc(2); pulse(s);
          chk("R8 quiet after nack", 32'(s), 1);
        end
      end
      bus_stop();
      chk("R9 stop event", 32'(evt_flags), 1);
      chk("R9 stop flag", 32'(stat_flags[5]), 1);
      chk("R9 lines released", 32'({scl_drive_low, sda_drive_low}), 0);
      host_cmd(1'b0, 16'h0049);
    end

    // R10 mask and R4 no stretch without stall enable
    host_adr(8'h84);
    host_cmd(1'b0, 16'h0050);
    bus_start();
    send_byte(8'h84, ack);
    chk("R2 ack with stall off", 32'(ack), 1);
    chk("R10 masked event", 32'(evt_flags), 1);
    chk("R10 irq masked", 32'(irq), 0);
    chk("R4 no stretch", 32'(scl_drive_low), 0);
    host_cmd(1'b0, 16'h0019);
    chk("R11 no clear keeps event", 32'(evt_flags), 1);
    chk("R10 still masked", 32'(irq), 0);
    host_cmd(1'b0, 16'h0009);
    chk("R10 unmask raises irq", 32'(irq), 1);
    bus_stop();
    host_cmd(1'b0, 16'h0049);
    chk("R11 final clear", 32'(evt_flags), 0);
    chk("R10 irq after clear", 32'(irq), 0);
    finish_run();
  end
endmodule